// File: doc/BRIEF.md
# Two-Level Segment and Page Address Translator

This block maps a virtual word reference onto a 24-bit physical word address. A reference is a 15-bit segment number and an 18-bit word offset within that segment. In append mode the translator first fetches the segment's descriptor word from a descriptor table in memory. It then fetches the page entry named by the upper offset bits, and joins that entry's frame number with the low ten offset bits. In absolute mode it skips both lookups and reaches only the low 256K words of memory.

Requests arrive on a valid/ready handshake and carry a flag that picks either the current-process segment register or a temporary segment number that comes with the request. The translator holds one request at a time. Table words move over a single synchronous word-memory port. When a write touches a present page whose modified flag is clear, the translator writes that page entry back with the flag set. The answer is a physical address or a fault code. Four configuration values (descriptor table base, table length, append-mode enable, current-process segment) load together on a single write strobe.

Memory word layouts (36-bit words): a descriptor holds the page-list base address in bits [23:0] and the page count (0 to 256) in bits [32:24]. A page entry holds the present flag in bit 35, the modified flag in bit 34 and the 14-bit frame number in bits [13:0]. Bits 33 to 14 of a page entry are carried along unchanged. The descriptor for segment s sits at table base + s. The entry for page p sits at page-list base + p.

Top module: `seg_xlate`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid` is 0 and `mem_en` is 0. The block is in absolute mode with a table length of zero.
- R2: In absolute mode the response has fault code 0 (none) and the address is the 18-bit offset zero-extended to 24 bits. No memory access is made.
- R3: In append mode, a segment number greater than or equal to the table length returns fault code 1 (segment fault). No memory access is made.
- R4: The segment used is the request's `req_seg` when `req_use_tmp` is 1, and the current-process segment register otherwise. Its descriptor is read at table base + segment.
- R5: A page index (offset bits [17:10]) greater than or equal to the descriptor's page count returns fault code 2 (bound fault) after exactly one memory read.
- R6: A page entry with the present bit (35) clear returns fault code 3 (page fault) after exactly two memory reads.
- R7: A present page entry yields the address {entry bits [13:0], offset bits [9:0]} with fault code 0.
- R8: A write to a present page whose modified bit (34) is clear causes exactly one memory write to the same entry address. The written word equals the entry read, with bit 34 set. Reads, and writes to pages already marked modified, cause no memory write.
- R9: `req_ready` is 0 from the acceptance of a request until its response is taken. While `rsp_valid` is 1 and `rsp_ready` is 0, the response fields stay unchanged.
- R10: Every faulting response reports a physical address of zero.
- R11: A configuration write in the same cycle that a request is accepted does not affect that request. The request is judged with the configuration held before that edge, and later requests see the new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Load all configuration values |
| cfg_append | input | 1 | 1 = append (translated) mode, 0 = absolute |
| cfg_dt_base | input | 24 | Descriptor table base address |
| cfg_dt_len | input | 16 | Number of valid descriptor entries |
| cfg_cur_seg | input | 15 | Current-process segment number |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Translator can accept a request |
| req_use_tmp | input | 1 | Use `req_seg` instead of the current-process segment |
| req_seg | input | 15 | Temporary segment number |
| req_offset | input | 18 | Word offset within the segment |
| req_write | input | 1 | Reference is a write |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken |
| rsp_fault | output | 2 | 0 none, 1 segment, 2 bound, 3 page |
| rsp_paddr | output | 24 | Physical word address |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write (else read) |
| mem_addr | output | 24 | Memory word address |
| mem_wdata | output | 36 | Memory write data |
| mem_rdata | input | 36 | Memory read data, one cycle after a read strobe |

## Verification
Two events can meet on one clock edge: a configuration load and the acceptance of a request. The bench provokes this by raising `cfg_we` with a new table length, segment register or mode in the same cycle as `req_valid` while the translator is idle. The expected result is computed from the old configuration. A following request is then judged against the new one. The random traffic mixes stalled response handshakes with write-backs, so the bench also checks that the modified-bit write lands before the response while the response holds steady under back-pressure.

// File: rtl/seg_xlate_pkg.sv
// Package: shared fault codes and walker state encoding for the translator.
// Assumes: fault code values are visible at the top-level ports.
package seg_xlate_pkg;
    typedef enum logic [1:0] {
        FLT_NONE  = 2'd0,
        FLT_SEG   = 2'd1,
        FLT_BOUND = 2'd2,
        FLT_PAGE  = 2'd3
    } fault_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DRD,
        ST_DEVAL,
        ST_PRD,
        ST_PEVAL,
        ST_WB,
        ST_RESP
    } walk_st_e;
endpackage

// File: rtl/seg_xlate_cfg.sv
// Module: seg_xlate_cfg
// Holds the descriptor table base, table length, mode and current-process
// segment. All four load together on cfg_we. Reset selects absolute mode
// and clears base and length.
// Assumes: readers sample these values at a clock edge, so a load on the
// same edge is seen only by later cycles.
module seg_xlate_cfg #(
    parameter int SEG_W = 15,
    parameter int PA_W  = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_append,
    input  logic [PA_W-1:0]  cfg_dt_base,
    input  logic [SEG_W:0]   cfg_dt_len,
    input  logic [SEG_W-1:0] cfg_cur_seg,
    output logic             append_q,
    output logic [PA_W-1:0]  dt_base_q,
    output logic [SEG_W:0]   dt_len_q,
    output logic [SEG_W-1:0] cur_seg_q
);
    // Configuration register load and reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            append_q  <= 1'b0;
            dt_base_q <= '0;
            dt_len_q  <= '0;
            cur_seg_q <= '0;
        end else if (cfg_we) begin
            append_q  <= cfg_append;
            dt_base_q <= cfg_dt_base;
            dt_len_q  <= cfg_dt_len;
            cur_seg_q <= cfg_cur_seg;
        end
    end

    // R1: reset leaves the block in absolute mode with an empty table.
    p_reset_abs_r1: assert property (@(posedge clk)
        !rst_n |=> (!append_q && dt_len_q == '0));
endmodule

// File: rtl/seg_xlate_walk.sv
// Module: seg_xlate_walk
// Walks descriptor then page entry for one request at a time, sets the
// modified flag by write-back, and holds the response until it is taken.
// Assumes: synchronous memory with read data one cycle after the strobe.
module seg_xlate_walk
    import seg_xlate_pkg::*;
#(
    parameter int SEG_W  = 15,
    parameter int OFF_W  = 18,
    parameter int PAGE_W = 10,
    parameter int PA_W   = 24,
    parameter int WORD_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              append_q,
    input  logic [PA_W-1:0]   dt_base_q,
    input  logic [SEG_W:0]    dt_len_q,
    input  logic [SEG_W-1:0]  cur_seg_q,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_use_tmp,
    input  logic [SEG_W-1:0]  req_seg,
    input  logic [OFF_W-1:0]  req_offset,
    input  logic              req_write,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [1:0]        rsp_fault,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic              mem_en,
    output logic              mem_we,
    output logic [PA_W-1:0]   mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata
);
    localparam int PIDX_W   = OFF_W - PAGE_W;
    localparam int CNT_W    = PIDX_W + 1;
    localparam int FRAME_W  = PA_W - PAGE_W;
    localparam int PRES_BIT = WORD_W - 1;
    localparam int MOD_BIT  = WORD_W - 2;

    walk_st_e           st;
    logic               abs_q, wr_q;
    logic [OFF_W-1:0]   off_q;
    logic [PA_W-1:0]    wadr_q;
    logic [WORD_W-1:0]  pte_q;
    fault_e             fault_q;
    logic [PA_W-1:0]    paddr_q;

    logic [SEG_W-1:0]   seg_sel;
    logic [CNT_W-1:0]   d_cnt;
    logic [PA_W-1:0]    d_list;
    logic [PIDX_W-1:0]  pidx;
    logic               accept;

    // Request decode: segment source, descriptor fields, page index.
    always_comb begin
        seg_sel = req_use_tmp ? req_seg : cur_seg_q;
        d_cnt   = mem_rdata[PA_W +: CNT_W];
        d_list  = mem_rdata[PA_W-1:0];
        pidx    = off_q[OFF_W-1:PAGE_W];
        accept  = (st == ST_IDLE) && req_valid;
    end

    // Walk sequencer: one request from acceptance to response handoff.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            abs_q   <= 1'b0;
            wr_q    <= 1'b0;
            off_q   <= '0;
            wadr_q  <= '0;
            pte_q   <= '0;
            fault_q <= FLT_NONE;
            paddr_q <= '0;
        end else begin
            case (st)
                ST_IDLE: if (req_valid) begin
                    off_q   <= req_offset;
                    wr_q    <= req_write;
                    abs_q   <= !append_q;
                    fault_q <= FLT_NONE;
                    paddr_q <= '0;
                    if (!append_q) begin
                        paddr_q <= PA_W'(req_offset);
                        st      <= ST_RESP;
                    end else if ({1'b0, seg_sel} >= dt_len_q) begin
                        fault_q <= FLT_SEG;
                        st      <= ST_RESP;
                    end else begin
                        wadr_q <= dt_base_q + PA_W'(seg_sel);
                        st     <= ST_DRD;
                    end
                end
                ST_DRD:   st <= ST_DEVAL;
                ST_DEVAL: begin
                    if ({1'b0, pidx} >= d_cnt) begin
                        fault_q <= FLT_BOUND;
                        st      <= ST_RESP;
                    end else begin
                        wadr_q <= d_list + PA_W'(pidx);
                        st     <= ST_PRD;
                    end
                end
                ST_PRD:   st <= ST_PEVAL;
                ST_PEVAL: begin
                    pte_q <= mem_rdata;
                    if (!mem_rdata[PRES_BIT]) begin
                        fault_q <= FLT_PAGE;
                        st      <= ST_RESP;
                    end else begin
                        paddr_q <= {mem_rdata[FRAME_W-1:0], off_q[PAGE_W-1:0]};
                        st      <= (wr_q && !mem_rdata[MOD_BIT]) ? ST_WB : ST_RESP;
                    end
                end
                ST_WB:    st <= ST_RESP;
                ST_RESP:  if (rsp_ready) st <= ST_IDLE;
                default:  st <= ST_IDLE;
            endcase
        end
    end

    // Port drive: handshake flags, response fields, memory strobes.
    always_comb begin
        req_ready = (st == ST_IDLE);
        rsp_valid = (st == ST_RESP);
        rsp_fault = fault_q;
        rsp_paddr = paddr_q;
        mem_en    = (st == ST_DRD) || (st == ST_PRD) || (st == ST_WB);
        mem_we    = (st == ST_WB);
        mem_addr  = wadr_q;
        mem_wdata = pte_q | (WORD_W'(1) << MOD_BIT);
    end

    // R2: absolute responses never exceed the low 256K-word window.
    p_abs_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && abs_q) |-> (rsp_fault == FLT_NONE && rsp_paddr[PA_W-1:OFF_W] == '0));
    // R3: a segment fault goes straight to the response with no memory access.
    p_segflt_nomem_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && append_q && ({1'b0, seg_sel} >= dt_len_q)) |=> (rsp_valid && !mem_en));
    // R8: write-back targets the entry read two cycles earlier and sets both flags.
    p_wb_same_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_en && mem_wdata[MOD_BIT] && mem_wdata[PRES_BIT]
                    && $past(mem_en, 2) && !$past(mem_we, 2)
                    && mem_addr == $past(mem_addr, 2)));
    // R9: a stalled response holds its fields.
    p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_fault) && $stable(rsp_paddr)));
    // R9: no new request is taken while a response is pending.
    p_busy_noready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);
    // R10: faulting responses carry no address.
    p_fault_noaddr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault != FLT_NONE) |-> (rsp_paddr == '0));
endmodule

// File: rtl/seg_xlate.sv
// Module: seg_xlate (top)
// Segment-then-page address translator. Configuration registers feed a
// single-request walker that uses a shared synchronous word memory.
// Assumes: the memory answers each read in the following cycle.
module seg_xlate #(
    parameter int SEG_W  = 15,
    parameter int OFF_W  = 18,
    parameter int PAGE_W = 10,
    parameter int PA_W   = 24,
    parameter int WORD_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_append,
    input  logic [PA_W-1:0]   cfg_dt_base,
    input  logic [SEG_W:0]    cfg_dt_len,
    input  logic [SEG_W-1:0]  cfg_cur_seg,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_use_tmp,
    input  logic [SEG_W-1:0]  req_seg,
    input  logic [OFF_W-1:0]  req_offset,
    input  logic              req_write,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [1:0]        rsp_fault,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic              mem_en,
    output logic              mem_we,
    output logic [PA_W-1:0]   mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata
);
    logic             append_q;
    logic [PA_W-1:0]  dt_base_q;
    logic [SEG_W:0]   dt_len_q;
    logic [SEG_W-1:0] cur_seg_q;

    seg_xlate_cfg #(.SEG_W(SEG_W), .PA_W(PA_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we),
        .cfg_append(cfg_append), .cfg_dt_base(cfg_dt_base),
        .cfg_dt_len(cfg_dt_len), .cfg_cur_seg(cfg_cur_seg),
        .append_q(append_q), .dt_base_q(dt_base_q),
        .dt_len_q(dt_len_q), .cur_seg_q(cur_seg_q)
    );

    seg_xlate_walk #(
        .SEG_W(SEG_W), .OFF_W(OFF_W), .PAGE_W(PAGE_W),
        .PA_W(PA_W), .WORD_W(WORD_W)
    ) u_walk (
        .clk(clk), .rst_n(rst_n),
        .append_q(append_q), .dt_base_q(dt_base_q),
        .dt_len_q(dt_len_q), .cur_seg_q(cur_seg_q),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_use_tmp(req_use_tmp), .req_seg(req_seg),
        .req_offset(req_offset), .req_write(req_write),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // R1: the memory port stays quiet while reset is held.
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!mem_en && !rsp_valid && req_ready));
endmodule

// File: tb/seg_xlate_bench.sv
module seg_xlate_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NRAND      = 300;
    localparam int NSEG       = 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0, cfg_append = 1'b0;
    logic [23:0] cfg_dt_base = '0;
    logic [15:0] cfg_dt_len = '0;
    logic [14:0] cfg_cur_seg = '0;
    logic        req_valid = 1'b0, req_use_tmp = 1'b0, req_write = 1'b0;
    logic        req_ready;
    logic [14:0] req_seg = '0;
    logic [17:0] req_offset = '0;
    logic        rsp_valid, rsp_ready = 1'b0;
    logic [1:0]  rsp_fault;
    logic [23:0] rsp_paddr;
    logic        mem_en, mem_we;
    logic [23:0] mem_addr;
    logic [35:0] mem_wdata;
    logic [35:0] mem_rdata = '0;

    seg_xlate u_seg_xlate (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_append(cfg_append),
        .cfg_dt_base(cfg_dt_base), .cfg_dt_len(cfg_dt_len), .cfg_cur_seg(cfg_cur_seg),
        .req_valid(req_valid), .req_ready(req_ready), .req_use_tmp(req_use_tmp),
        .req_seg(req_seg), .req_offset(req_offset), .req_write(req_write),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_fault(rsp_fault),
        .rsp_paddr(rsp_paddr), .mem_en(mem_en), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0, n_bad = 0;
    logic [35:0] mem [int];
    int acc_cnt = 0, wr_cnt = 0;
    logic [23:0] wr_addr = '0;
    logic [35:0] wr_data = '0;

    // model of the configuration as the bench believes it
    logic        m_append = 1'b0;
    logic [23:0] m_base = '0;
    logic [15:0] m_len = '0;
    logic [14:0] m_cur = '0;

    function automatic logic [35:0] rd(input logic [23:0] a);
        if (mem.exists(int'(a))) return mem[int'(a)];
        return '0;
    endfunction

    // memory model: one-cycle read latency, counts accesses
    always @(posedge clk) begin
        if (mem_en) begin
            acc_cnt = acc_cnt + 1;
            if (mem_we) begin
                mem[int'(mem_addr)] = mem_wdata;
                wr_cnt  = wr_cnt + 1;
                wr_addr = mem_addr;
                wr_data = mem_wdata;
            end else begin
                mem_rdata <= rd(mem_addr);
            end
        end
    end

    task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // expected outcome from the requirement text
    task automatic expect_xl(input logic use_tmp, input logic [14:0] seg, input logic [17:0] off,
                             input logic wr, output logic [1:0] f, output logic [23:0] pa,
                             output int nacc, output logic do_wb, output logic [23:0] wa,
                             output logic [35:0] wd);
        logic [14:0] s;
        logic [35:0] d, p;
        do_wb = 1'b0; wa = '0; wd = '0; pa = '0; nacc = 0; f = 2'd0;
        s = use_tmp ? seg : m_cur;
        if (!m_append) begin
            pa = {6'b0, off};
            return;
        end
        if ({1'b0, s} >= m_len) begin f = 2'd1; return; end
        d = rd(m_base + {9'b0, s});
        nacc = 1;
        if ({1'b0, off[17:10]} >= d[32:24]) begin f = 2'd2; return; end
        wa = d[23:0] + {16'b0, off[17:10]};
        p = rd(wa);
        nacc = 2;
        if (!p[35]) begin f = 2'd3; return; end
        pa = {p[13:0], off[9:0]};
        if (wr && !p[34]) begin
            do_wb = 1'b1; wd = p | (36'd1 << 34); nacc = 3;
        end
    endtask

    task automatic cfg_load(input logic ap, input logic [23:0] b, input logic [15:0] l, input logic [14:0] c);
        @(negedge clk);
        cfg_we = 1'b1; cfg_append = ap; cfg_dt_base = b; cfg_dt_len = l; cfg_cur_seg = c;
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
        m_append = ap; m_base = b; m_len = l; m_cur = c;
    endtask

    // one request; optional config load in the acceptance cycle (R11)
    task automatic do_req(input logic use_tmp, input logic [14:0] seg, input logic [17:0] off,
                          input logic wr, input int stall, input string tag,
                          input logic with_cfg, input logic ap, input logic [15:0] nl,
                          input logic [14:0] nc);
        logic [1:0] ef; logic [23:0] epa; int enacc; logic ewb; logic [23:0] ewa; logic [35:0] ewd;
        logic rdy_seen; logic [1:0] hf; logic [23:0] hpa; logic moved;
        expect_xl(use_tmp, seg, off, wr, ef, epa, enacc, ewb, ewa, ewd);
        @(negedge clk);
        acc_cnt = 0; wr_cnt = 0;
        req_valid = 1'b1; req_use_tmp = use_tmp; req_seg = seg; req_offset = off; req_write = wr;
        if (with_cfg) begin
            cfg_we = 1'b1; cfg_append = ap; cfg_dt_base = m_base; cfg_dt_len = nl; cfg_cur_seg = nc;
        end
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        if (with_cfg) begin
            cfg_we = 1'b0; m_append = ap; m_len = nl; m_cur = nc;
        end
        rdy_seen = 1'b0;
        for (int i = 0; i < 20 && !rsp_valid; i++) begin
            if (req_ready) rdy_seen = 1'b1;
            @(negedge clk);
        end
        if (req_ready) rdy_seen = 1'b1;
        chk(rsp_valid, {tag, " R9 response arrives"}, rsp_valid, 1);
        chk(!rdy_seen, {tag, " R9 ready low while busy"}, rdy_seen, 0);
        chk(rsp_fault == ef, {tag, " fault code"}, rsp_fault, ef);
        chk(rsp_paddr == epa, {tag, " physical address"}, rsp_paddr, epa);
        chk(acc_cnt == enacc, {tag, " memory access count"}, acc_cnt, enacc);
        chk(wr_cnt == (ewb ? 1 : 0), {tag, " R8 write-back count"}, wr_cnt, ewb);
        if (ewb) begin
            chk(wr_addr == ewa, {tag, " R8 write-back address"}, wr_addr, ewa);
            chk(wr_data == ewd, {tag, " R8 write-back data"}, wr_data, ewd);
        end
        hf = rsp_fault; hpa = rsp_paddr; moved = 1'b0;
        for (int i = 0; i < stall; i++) begin
            @(negedge clk);
            if (!rsp_valid || rsp_fault != hf || rsp_paddr != hpa || req_ready) moved = 1'b1;
        end
        if (stall > 0) chk(!moved, {tag, " R9 response held under stall"}, moved, 0);
        rsp_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rsp_ready = 1'b0;
        chk(req_ready && !rsp_valid, {tag, " R9 idle after handoff"}, {req_ready, rsp_valid}, 2'b10);
    endtask

    task automatic req(input logic use_tmp, input logic [14:0] seg, input logic [17:0] off,
                       input logic wr, input int stall, input string tag);
        do_req(use_tmp, seg, off, wr, stall, tag, 1'b0, 1'b0, '0, '0);
    endtask

    localparam logic [23:0] DT_BASE = 24'h010040;

    // page-list base for segment s
    function automatic logic [23:0] lbase(input int s);
        return 24'h100000 + 24'(s * 512);
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd1234));
        // build descriptor table and page lists
        for (int s = 0; s < NSEG; s++) begin
            logic [8:0] cnt;
            case (s)
                0: cnt = 9'd256;
                1: cnt = 9'd0;
                2: cnt = 9'd5;
                default: cnt = 9'($urandom_range(0, 256));
            endcase
            mem[int'(DT_BASE + 24'(s))] = {3'($urandom), cnt, lbase(s)};
            for (int p = 0; p < 256; p++) begin
                logic [35:0] e;
                e = {1'($urandom_range(0, 3) != 0), 1'($urandom), 20'($urandom), 14'($urandom)};
                mem[int'(lbase(s) + 24'(p))] = e;
            end
        end
        // fixed entries for directed cases
        mem[int'(lbase(0) + 24'd255)] = {2'b10, 20'hABCDE, 14'h3FFF};
        mem[int'(lbase(0) + 24'd3)]   = {2'b01, 20'h12345, 14'h0123};
        mem[int'(lbase(0) + 24'd7)]   = {2'b11, 20'h0F0F0, 14'h0777};
        mem[int'(lbase(2) + 24'd4)]   = {2'b10, 20'h00000, 14'h1555};
        mem[int'(lbase(2) + 24'd5)]   = {2'b10, 20'h00000, 14'h2AAA};

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
        chk(rsp_valid == 1'b0, "R1 no response after reset", rsp_valid, 0);
        chk(mem_en == 1'b0, "R1 memory idle after reset", mem_en, 0);
        // R1/R2: absolute mode out of reset
        req(1'b1, 15'd5, 18'h3FFFF, 1'b1, 2, "R1 R2 absolute after reset");
        req(1'b0, 15'd0, 18'h00000, 1'b0, 0, "R2 absolute zero offset");

        cfg_load(1'b1, DT_BASE, 16'(NSEG), 15'd0);
        // R7 / R8 directed
        req(1'b0, 15'd9, 18'h3FC00 | 18'h155, 1'b0, 0, "R4 R7 cur seg last page read");
        req(1'b0, 15'd9, 18'h3FC00 | 18'h2AA, 1'b1, 1, "R8 write sets modified");
        req(1'b0, 15'd9, 18'h3FC00 | 18'h001, 1'b1, 0, "R8 second write no write-back");
        req(1'b1, 15'd0, 18'h01C00, 1'b1, 0, "R8 already modified no write-back");
        req(1'b1, 15'd0, 18'h00C00, 1'b0, 0, "R6 page not present");
        req(1'b1, 15'd1, 18'h00000, 1'b0, 0, "R5 zero page count");
        req(1'b1, 15'd2, 18'h01000 | 18'h3FF, 1'b0, 0, "R5 R7 last page inside bound");
        req(1'b1, 15'd2, 18'h01400, 1'b0, 3, "R5 R10 first page past bound");
        req(1'b1, 15'(NSEG-1), 18'h00000, 1'b0, 0, "R3 last valid segment");
        req(1'b1, 15'(NSEG), 18'h00000, 1'b0, 2, "R3 R10 segment at length");
        req(1'b1, 15'h7FFF, 18'h3FFFF, 1'b1, 0, "R3 largest segment");
        // R11: config load in acceptance cycle
        do_req(1'b0, 15'd0, 18'h00400, 1'b0, 0, "R11 old length used", 1'b1, 1'b1, 16'd0, 15'd3);
        req(1'b0, 15'd0, 18'h00400, 1'b0, 0, "R11 new length seen");
        do_req(1'b0, 15'd0, 18'h2A400, 1'b0, 0, "R11 old mode used", 1'b1, 1'b0, 16'(NSEG), 15'd2);
        req(1'b0, 15'd0, 18'h00400, 1'b0, 0, "R11 R2 new absolute mode");
        do_req(1'b0, 15'd0, 18'h01000, 1'b0, 0, "R11 old absolute mode", 1'b1, 1'b1, 16'(NSEG), 15'd2);
        req(1'b0, 15'd0, 18'h01000, 1'b0, 0, "R11 R4 new cur seg");

        // random traffic
        for (int k = 0; k < NRAND; k++) begin
            logic [14:0] s;
            s = ($urandom_range(0, 9) == 0) ? 15'($urandom) : 15'($urandom_range(0, NSEG + 3));
            if ($urandom_range(0, 39) == 0)
                cfg_load(1'($urandom_range(0, 7) != 0), DT_BASE, 16'(NSEG), 15'($urandom_range(0, NSEG)));
            req(1'($urandom), s, 18'($urandom), 1'($urandom), $urandom_range(0, 3), "R4-mix random");
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule